// File: doc/BRIEF.md
# GPIO Interrupt Trigger Detector

This block turns sampled GPIO pin levels into interrupt requests for one bank of general-purpose I/O. A bank holds `NPORT` ports of `PINS` pins each. Each pin has its own trigger type: active-low level, active-high level, rising edge, falling edge, or either edge. When the selected condition occurs, a pending bit is latched for that pin. That bit stays set until software clears it. A per-pin enable mask gates the pending bits into one request per port. The port requests are then OR-ed into a single request line for the bank.

Software reaches the block through three write strobes that share one port-select bus and one data bus. The type strobe loads the selected port's trigger configuration. The enable strobe performs a masked write of the enable bits. The clear strobe is write-one-to-clear on the pending bits. The pin levels arrive already synchronised.

Each pin carries a two-state machine. `ST_IDLE` moves to `ST_PEND` on the cycle its trigger condition is seen. `ST_PEND` moves back to `ST_IDLE` only on a clear write to that pin in a cycle with no new trigger. In every other case each state holds.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is low, every pending bit, every enable bit and every trigger configuration is zero. In the first cycle after reset, `irq_status_o`, `port_irq_o` and `bank_irq_o` are all zero.
- R2: Level modes use {delta,edge,pol} = 000 for active-low and 001 for active-high. A pending bit is set in any cycle the pin is at the active level. A clear written while that level is still present leaves the bit set.
- R3: Rising mode ({delta,edge,pol} = 011) sets the pending bit when the pin sample is 1 and the previous sample was 0. It does nothing on a falling transition.
- R4: Falling mode ({delta,edge,pol} = 010) sets the pending bit on a 1-to-0 transition. It does nothing on a rising transition.
- R5: Both-edge mode ({delta,edge} = 11) sets the pending bit on any change of the pin sample, whatever the pol bit holds.
- R6: A pending bit stays set when its condition goes away, such as the pin returning to its earlier level. It is cleared only by a clear write.
- R7: A clear write clears the pending bit of pin j of the selected port when `wr_data_i[j]` is 1. Data bits at 0 leave their pending bits unchanged.
- R8: If a clear write and a new trigger event for the same pin occur in the same cycle, the pending bit stays set.
- R9: An enable write updates enable bit j of the selected port to `wr_data_i[j]` only where the mask bit `wr_data_i[PINS+j]` is 1. All other enable bits keep their values.
- R10: `port_irq_o[p]` is the OR over the pins of port p of (pending AND enable). `bank_irq_o` is the OR of all port requests.
- R11: A write of any kind acts only on the port whose index equals `wr_sel_i`. Within a type write, the bits for pin j sit at pol = bit j, edge = bit PINS+j and delta = bit 2*PINS+j of `wr_data_i`.
- R12: With the edge bit at 0, the delta bit is ignored, and the pin follows the level mode chosen by pol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl_i | input | NPORT*PINS | Synchronised pin levels; port p occupies bits [p*PINS +: PINS] |
| wr_sel_i | input | SELW | Port targeted by a write |
| typ_we_i | input | 1 | Load the trigger configuration of the selected port |
| ena_we_i | input | 1 | Masked write of the enable bits of the selected port |
| clr_we_i | input | 1 | Write-one-to-clear of the pending bits of the selected port |
| wr_data_i | input | 3*PINS | Write data for all three strobes |
| irq_status_o | output | NPORT*PINS | Pending bits, laid out like `pin_lvl_i` |
| port_irq_o | output | NPORT | Per-port interrupt request |
| bank_irq_o | output | 1 | Bank interrupt request |

## Verification
The bench builds the block with its defaults, `PINS = 8` and `NPORT = 4`. With these values the type-register fields sit at bit offsets 8 and 16. Four ports let the select decode steer writes to a port other than 0 while neighbouring ports are checked for unchanged pending and request bits. Every legal trigger code, plus the two codes with delta set and edge clear, is run on one pin through a pair of pin transitions. This shows both the transition that fires and the one that must not.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        TRIG_LVL_LO,
        TRIG_LVL_HI,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_BOTH
    } trig_e;

    typedef enum logic {
        ST_IDLE,
        ST_PEND
    } pend_e;

    // edg = 0 selects a level mode and ignores dlt; edg = 1 with dlt = 1 ignores pol
    function automatic trig_e decode_trig(input logic pol, input logic edg, input logic dlt);
        trig_e k;
        if (!edg)
            k = pol ? TRIG_LVL_HI : TRIG_LVL_LO;
        else if (dlt)
            k = TRIG_BOTH;
        else
            k = pol ? TRIG_RISE : TRIG_FALL;
        return k;
    endfunction

endpackage

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pol_i,
    input  logic edg_i,
    input  logic dlt_i,
    input  logic clr_i,
    output logic pend_o
);

    logic  prev_q;
    trig_e kind;
    logic  hit;
    pend_e state_q;
    pend_e state_d;

    // Tracks the pin during reset as well, so the first cycle after reset sees no false edge
    always_ff @(posedge clk) begin
        prev_q <= pin_i;
    end

    always_comb begin
        kind = decode_trig(pol_i, edg_i, dlt_i);
        unique case (kind)
            TRIG_LVL_LO: hit = ~pin_i;
            TRIG_LVL_HI: hit = pin_i;
            TRIG_RISE:   hit = pin_i & ~prev_q;
            TRIG_FALL:   hit = ~pin_i & prev_q;
            TRIG_BOTH:   hit = pin_i ^ prev_q;
            default:     hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit) state_d = ST_PEND;
            ST_PEND: if (clr_i && !hit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == ST_PEND);
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
    parameter int PINS = 8,
    localparam int DW = 3 * PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins_i,
    input  logic            cfg_we_i,
    input  logic            en_we_i,
    input  logic            clr_we_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [PINS-1:0] pend_o,
    output logic            irq_o
);

    logic [DW-1:0]   cfg_q;
    logic [PINS-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we_i)
            cfg_q <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we_i) begin
            for (int j = 0; j < PINS; j++) begin
                if (wdata_i[PINS + j])
                    en_q[j] <= wdata_i[j];
            end
        end
    end

    for (genvar j = 0; j < PINS; j++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins_i[j]),
            .pol_i  (cfg_q[j]),
            .edg_i  (cfg_q[PINS + j]),
            .dlt_i  (cfg_q[2*PINS + j]),
            .clr_i  (clr_we_i & wdata_i[j]),
            .pend_o (pend_o[j])
        );
    end

    always_comb begin
        irq_o = |(pend_o & en_q);
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int PINS  = 8,
    parameter int NPORT = 4,
    localparam int SELW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int NPIN = NPORT * PINS,
    localparam int DW   = 3 * PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_lvl_i,
    input  logic [SELW-1:0] wr_sel_i,
    input  logic            typ_we_i,
    input  logic            ena_we_i,
    input  logic            clr_we_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [NPIN-1:0] irq_status_o,
    output logic [NPORT-1:0] port_irq_o,
    output logic            bank_irq_o
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic sel_hit;
        assign sel_hit = (wr_sel_i == SELW'(p));

        gpio_irq_port #(.PINS(PINS)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .pins_i   (pin_lvl_i[p*PINS +: PINS]),
            .cfg_we_i (typ_we_i & sel_hit),
            .en_we_i  (ena_we_i & sel_hit),
            .clr_we_i (clr_we_i & sel_hit),
            .wdata_i  (wr_data_i),
            .pend_o   (irq_status_o[p*PINS +: PINS]),
            .irq_o    (port_irq_o[p])
        );
    end

    always_comb begin
        bank_irq_o = |port_irq_o;
    end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int PINS  = 8,
    parameter int NPORT = 4,
    localparam int SELW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int NPIN = NPORT * PINS
) (
    input logic            clk,
    input logic            rst_n,
    input logic [SELW-1:0] wr_sel_i,
    input logic            clr_we_i,
    input logic [PINS-1:0] clr_bits_i,
    input logic [NPIN-1:0] irq_status_o,
    input logic [NPORT-1:0] port_irq_o,
    input logic            bank_irq_o
);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_status_o == '0 && bank_irq_o == 1'b0));

    for (genvar i = 0; i < NPIN; i++) begin : g_bit
        p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_status_o[i] && !(clr_we_i && wr_sel_i == SELW'(i / PINS) && clr_bits_i[i % PINS]))
            |=> irq_status_o[i]);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_prt
        p_port_needs_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
            port_irq_o[p] |-> (|irq_status_o[p*PINS +: PINS]));
    end

    p_bank_needs_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bank_irq_o |-> (|irq_status_o));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PINS(PINS), .NPORT(NPORT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_sel_i     (wr_sel_i),
    .clr_we_i     (clr_we_i),
    .clr_bits_i   (wr_data_i[PINS-1:0]),
    .irq_status_o (irq_status_o),
    .port_irq_o   (port_irq_o),
    .bank_irq_o   (bank_irq_o)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;

    localparam int PINS  = 8;
    localparam int NPORT = 4;
    localparam int NPIN  = PINS * NPORT;
    localparam int J     = 3;

    // {req[3:0], typ{delta,edge,pol}[2:0], a, b, c, exp_b, exp_c}
    localparam logic [11:0] VEC [12] = '{
        {4'd2,  3'b000, 5'b10111},
        {4'd2,  3'b001, 5'b01011},
        {4'd2,  3'b001, 5'b00000},
        {4'd3,  3'b011, 5'b01011},
        {4'd3,  3'b011, 5'b10000},
        {4'd4,  3'b010, 5'b10111},
        {4'd4,  3'b010, 5'b01100},
        {4'd5,  3'b110, 5'b00101},
        {4'd5,  3'b110, 5'b11001},
        {4'd5,  3'b111, 5'b01111},
        {4'd12, 3'b100, 5'b10111},
        {4'd12, 3'b101, 5'b00101}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pins = '1;
    logic [1:0]      sel = '0;
    logic            typ_we = 1'b0;
    logic            ena_we = 1'b0;
    logic            clr_we = 1'b0;
    logic [3*PINS-1:0] wdata = '0;
    logic [NPIN-1:0] status;
    logic [NPORT-1:0] pirq;
    logic            birq;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    gpio_irq_bank #(.PINS(PINS), .NPORT(NPORT)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_lvl_i    (pins),
        .wr_sel_i     (sel),
        .typ_we_i     (typ_we),
        .ena_we_i     (ena_we),
        .clr_we_i     (clr_we),
        .wr_data_i    (wdata),
        .irq_status_o (status),
        .port_irq_o   (pirq),
        .bank_irq_o   (birq)
    );

    function automatic string tag(input int n);
        case (n)
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            5:       return "R5";
            12:      return "R12";
            default: return "R0";
        endcase
    endfunction

    task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", t, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int kind, input logic [1:0] s, input logic [3*PINS-1:0] d);
        sel = s;
        wdata = d;
        typ_we = (kind == 0);
        ena_we = (kind == 1);
        clr_we = (kind == 2);
        tick();
        typ_we = 1'b0;
        ena_we = 1'b0;
        clr_we = 1'b0;
        wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pins = '1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 status", 64'(status), 64'h0);
        chk("R1 port irq", 64'(pirq), 64'h0);
        chk("R1 bank irq", 64'(birq), 64'h0);

        // Table of trigger modes on port 0 pin J
        for (int i = 0; i < 12; i++) begin
            automatic logic [11:0] v = VEC[i];
            automatic string t = tag(int'(v[11:8]));
            automatic logic [3*PINS-1:0] d = '0;
            d[J] = v[5];
            d[PINS + J] = v[6];
            d[2*PINS + J] = v[7];
            pins[J] = v[4];
            tick();
            tick();
            wr(0, 2'd0, d);
            wr(2, 2'd0, 24'(1) << J);
            chk({t, " after clear"}, 64'(status[J]), 64'h0);
            pins[J] = v[3];
            tick();
            chk({t, " first step"}, 64'(status[J]), 64'(v[1]));
            pins[J] = v[2];
            tick();
            chk({t, " second step R6"}, 64'(status[J]), 64'(v[0]));
        end

        // R2/R7/R9/R10/R11 directed
        do_reset();
        wr(0, 2'd0, 24'h0000FF);
        tick();
        chk("R2 level-high all pins", 64'(status[7:0]), 64'hFF);
        chk("R1 enable reset blocks irq", 64'(pirq), 64'h0);
        pins[7:0] = 8'h00;
        tick();
        chk("R6 level sticky", 64'(status[7:0]), 64'hFF);
        wr(2, 2'd0, 24'h000000);
        chk("R7 zero write no effect", 64'(status[7:0]), 64'hFF);
        wr(2, 2'd0, 24'h000005);
        chk("R7 clear bits 0 and 2", 64'(status[7:0]), 64'hFA);
        pins[0] = 1'b1;
        tick();
        chk("R2 level re-set", 64'(status[7:0]), 64'hFB);
        wr(2, 2'd0, 24'h000001);
        chk("R2 clear while active", 64'(status[7:0]), 64'hFB);
        chk("R11 other ports untouched", 64'(status[31:8]), 64'h0);
        wr(1, 2'd0, 24'h000404);
        chk("R9 enable on clear pin", 64'(pirq), 64'h0);
        wr(1, 2'd0, 24'h000808);
        chk("R10 port irq", 64'(pirq), 64'h1);
        chk("R10 bank irq", 64'(birq), 64'h1);
        wr(1, 2'd0, 24'h000400);
        chk("R9 unmasked bit kept", 64'(pirq), 64'h1);
        wr(1, 2'd0, 24'h000800);
        chk("R9 masked disable", 64'(pirq), 64'h0);
        chk("R10 bank low", 64'(birq), 64'h0);
        wr(0, 2'd2, 24'h000001);
        tick();
        wr(1, 2'd2, 24'h000101);
        chk("R11 port 2 status", 64'(status[31:8]), 64'h000100);
        chk("R11 port 2 irq", 64'(pirq), 64'h4);

        // R3/R6/R8 directed: clear and rising edge in the same cycle
        do_reset();
        wr(0, 2'd0, (24'(1) << J) | (24'(1) << (PINS + J)));
        pins[J] = 1'b0;
        tick();
        chk("R3 falling ignored", 64'(status[J]), 64'h0);
        pins[J] = 1'b1;
        tick();
        chk("R3 rising", 64'(status[J]), 64'h1);
        pins[J] = 1'b0;
        tick();
        chk("R6 edge sticky", 64'(status[J]), 64'h1);
        pins[J] = 1'b1;
        wr(2, 2'd0, 24'(1) << J);
        chk("R8 event beats clear", 64'(status[J]), 64'h1);
        wr(2, 2'd0, 24'(1) << J);
        chk("R7 clear without event", 64'(status[J]), 64'h0);

        summary();
        $finish;
    end

endmodule